// File: doc/BRIEF.md
# Wakeup and Select Issue Queue

This block holds instructions that have been dispatched but not yet sent to execution, and sends them out as soon as their operands are available, regardless of program order. Each slot stores two source tags, a ready flag for each, and a destination tag. Every cycle a selector picks up to `WIDTH` slots whose two sources are both ready and places them on `WIDTH` issue ports, oldest first.

The destination tags issued in one cycle are registered onto `WIDTH` wakeup buses for the next cycle. Every waiting slot compares both of its source tags against every bus. A match counts as ready in that same cycle, so a consumer can issue in the cycle right after its producer. Dispatch writes one instruction per cycle into the lowest free slot. A flush empties the queue.

Top module: `wakeup_select_iq`

## Requirements
- R1: After reset no issue port is valid and `disp_ready` is 1.
- R2: A source counts as ready when its stored ready bit is set or its tag equals any valid wakeup bus tag in the current cycle. The wakeup buses carry the destination tags issued in the previous cycle. A slot requests issue only when both of its sources count as ready.
- R3: An instruction whose last outstanding source is produced by an instruction issued in cycle n issues in cycle n+1 if it is granted a port.
- R4: At most `WIDTH` slots are granted per cycle, and only requesting slots are granted. Ports are filled from port 0 upward, so port k is valid only if port k-1 is valid.
- R5: Grants go oldest-first. A slot's age is 0 when it is written and rises by 1 each cycle it stays, saturating at 2^`AGE_W`-1. Port 0 gets the oldest requester. Equal ages go to the lower slot index.
- R6: A granted slot is freed in the cycle it issues. A dispatch goes into the lowest-index free slot, counting slots freed in that cycle. `disp_ready` is 0 when no slot is free, and a dispatch offered while `disp_ready` is 0 is dropped.
- R7: A dispatched source whose tag matches a valid wakeup bus tag in the dispatch cycle is stored as ready.
- R8: While `flush` is 1, no port issues, `disp_ready` is 0 and a dispatch is dropped. After a flush all slots are empty and the wakeup buses are idle.
- R9: With `WIDTH`=2, consider the chain A→{B,C,D}, {B,C}→E, {D,E}→F, with B..F dispatched before A. It issues A alone, then B and C, then D and E, then F, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue; suppress issue and dispatch this cycle |
| disp_valid | input | 1 | A dispatch is offered this cycle |
| disp_ready | output | 1 | A free slot exists and no flush is active |
| disp_src_l | input | TAG_W | Left source tag |
| disp_src_l_rdy | input | 1 | Left source already available |
| disp_src_r | input | TAG_W | Right source tag |
| disp_src_r_rdy | input | 1 | Right source already available |
| disp_dst | input | TAG_W | Destination tag |
| iss_valid | output | WIDTH | Per-port issue strobe |
| iss_dst | output | WIDTH*TAG_W | Per-port destination tag of the issued instruction, port k at bits k*TAG_W upward |

## Verification
The bench targets the points where this loop is most easily broken. The first is the one-cycle producer-to-consumer turn. A design that only consulted stored ready bits would insert a bubble into the dependence chain. The second is a dispatch that arrives while its producer's tag is on the bus. If that tag were missed, the consumer would never wake. The third is age ordering when the older slot sits at the higher index, and the saturated-age tie that must fall back to the lower index. A design that ranked by index, or compared ages the wrong way, would swap the ports. A full queue, a slot reused in its issue cycle, and a flush that overlaps a dispatch round this out. A long randomized run is compared cycle by cycle against an arithmetic model of the requirements.

// File: rtl/iq_pkg.sv
package iq_pkg;
   localparam int unsigned IQ_DEF_ENTRIES = 8;
   localparam int unsigned IQ_DEF_WIDTH   = 2;
   localparam int unsigned IQ_DEF_TAG_W   = 6;
   localparam int unsigned IQ_DEF_AGE_W   = 4;
endpackage

// File: rtl/iq_slot.sv
module iq_slot #(
   parameter int unsigned TAG_W = 6,
   parameter int unsigned WIDTH = 2,
   parameter int unsigned AGE_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   wr_en,
   input  logic [TAG_W-1:0]       wr_src_l,
   input  logic                   wr_rdy_l,
   input  logic [TAG_W-1:0]       wr_src_r,
   input  logic                   wr_rdy_r,
   input  logic [TAG_W-1:0]       wr_dst,
   input  logic                   grant,
   input  logic [WIDTH-1:0]       bus_vld,
   input  logic [WIDTH*TAG_W-1:0] bus_tag,
   output logic                   busy,
   output logic                   req,
   output logic [TAG_W-1:0]       dst,
   output logic [AGE_W-1:0]       age
);
   localparam logic [AGE_W-1:0] AGE_TOP = '1;

   logic [TAG_W-1:0] src_l, src_r;
   logic             rdy_l, rdy_r;
   logic [WIDTH-1:0] hit_l, hit_r, hit_wl, hit_wr;
   logic             live_l, live_r;

   // every source compared against every wakeup bus (R2, R7)
   for (genvar k = 0; k < WIDTH; k++) begin : g_cmp
      assign hit_l[k]  = bus_vld[k] && (bus_tag[k*TAG_W +: TAG_W] == src_l);
      assign hit_r[k]  = bus_vld[k] && (bus_tag[k*TAG_W +: TAG_W] == src_r);
      assign hit_wl[k] = bus_vld[k] && (bus_tag[k*TAG_W +: TAG_W] == wr_src_l);
      assign hit_wr[k] = bus_vld[k] && (bus_tag[k*TAG_W +: TAG_W] == wr_src_r);
   end

   assign live_l = rdy_l | (|hit_l);
   assign live_r = rdy_r | (|hit_r);
   assign req    = busy & live_l & live_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         src_l <= '0;
         src_r <= '0;
         rdy_l <= 1'b0;
         rdy_r <= 1'b0;
         dst   <= '0;
         age   <= '0;
      end else if (flush) begin
         busy <= 1'b0;
      end else if (wr_en) begin
         busy  <= 1'b1;
         src_l <= wr_src_l;
         src_r <= wr_src_r;
         rdy_l <= wr_rdy_l | (|hit_wl);
         rdy_r <= wr_rdy_r | (|hit_wr);
         dst   <= wr_dst;
         age   <= '0;
      end else if (grant) begin
         busy <= 1'b0;
      end else if (busy) begin
         rdy_l <= live_l;
         rdy_r <= live_r;
         if (age != AGE_TOP) age <= age + 1'b1;
      end
   end

   // R6
   slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant && !wr_en && !flush |=> !busy);
   // R2
   slot_ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rdy_l && rdy_r && !wr_en && !grant && !flush |=> req);
   // R7
   slot_disp_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !flush && (|hit_wl) && (|hit_wr) |=> req);
   // R5
   slot_age_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !flush |=> age == '0);
endmodule

// File: rtl/iq_pick.sv
module iq_pick #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned AGE_W   = 4,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [ENTRIES-1:0]       req,
   input  logic [ENTRIES*AGE_W-1:0] ages,
   output logic [ENTRIES-1:0]       gnt,
   output logic [WIDTH-1:0]         pv,
   output logic [WIDTH*IDX_W-1:0]   pidx
);
   logic [ENTRIES-1:0] taken;
   logic               found;
   logic [AGE_W-1:0]   best;
   logic [IDX_W-1:0]   bidx;

   // WIDTH passes, each takes the oldest untaken requester (R4, R5)
   always_comb begin
      taken = '0;
      pv    = '0;
      pidx  = '0;
      found = 1'b0;
      best  = '0;
      bidx  = '0;
      for (int k = 0; k < WIDTH; k++) begin
         found = 1'b0;
         best  = '0;
         bidx  = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (req[i] && !taken[i] &&
                (!found || ages[i*AGE_W +: AGE_W] > best)) begin
               found = 1'b1;
               best  = ages[i*AGE_W +: AGE_W];
               bidx  = IDX_W'(i);
            end
         end
         if (found) begin
            taken[bidx]               = 1'b1;
            pv[k]                     = 1'b1;
            pidx[k*IDX_W +: IDX_W]    = bidx;
         end
      end
      gnt = taken;
   end
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
   parameter int unsigned ENTRIES = 8
) (
   input  logic [ENTRIES-1:0] open,
   output logic               any,
   output logic [ENTRIES-1:0] onehot
);
   // lowest-index free slot (R6)
   always_comb begin
      onehot = '0;
      any    = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (open[i] && !any) begin
            onehot[i] = 1'b1;
            any       = 1'b1;
         end
      end
   end
endmodule

// File: rtl/wakeup_select_iq.sv
module wakeup_select_iq
   import iq_pkg::*;
#(
   parameter int unsigned ENTRIES = IQ_DEF_ENTRIES,
   parameter int unsigned WIDTH   = IQ_DEF_WIDTH,
   parameter int unsigned TAG_W   = IQ_DEF_TAG_W,
   parameter int unsigned AGE_W   = IQ_DEF_AGE_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   disp_valid,
   output logic                   disp_ready,
   input  logic [TAG_W-1:0]       disp_src_l,
   input  logic                   disp_src_l_rdy,
   input  logic [TAG_W-1:0]       disp_src_r,
   input  logic                   disp_src_r_rdy,
   input  logic [TAG_W-1:0]       disp_dst,
   output logic [WIDTH-1:0]       iss_valid,
   output logic [WIDTH*TAG_W-1:0] iss_dst
);
   localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (WIDTH < 1 || WIDTH > ENTRIES) begin : g_bad_width
      $error("wakeup_select_iq: WIDTH must lie in 1..ENTRIES");
   end
   if (TAG_W < 1 || AGE_W < 1) begin : g_bad_field
      $error("wakeup_select_iq: TAG_W and AGE_W must be positive");
   end

   logic [ENTRIES-1:0]       busy, req, req_eff, gnt, open, pick_slot, wr_en;
   logic [ENTRIES*AGE_W-1:0] ages_pk;
   logic [TAG_W-1:0]         slot_dst [ENTRIES];
   logic [WIDTH-1:0]         pv, bus_vld;
   logic [WIDTH*IDX_W-1:0]   pidx;
   logic [WIDTH*TAG_W-1:0]   bus_tag;
   logic                     any_open;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      iq_slot #(.TAG_W(TAG_W), .WIDTH(WIDTH), .AGE_W(AGE_W)) slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .wr_en    (wr_en[i]),
         .wr_src_l (disp_src_l),
         .wr_rdy_l (disp_src_l_rdy),
         .wr_src_r (disp_src_r),
         .wr_rdy_r (disp_src_r_rdy),
         .wr_dst   (disp_dst),
         .grant    (gnt[i]),
         .bus_vld  (bus_vld),
         .bus_tag  (bus_tag),
         .busy     (busy[i]),
         .req      (req[i]),
         .dst      (slot_dst[i]),
         .age      (ages_pk[i*AGE_W +: AGE_W])
      );
   end

   // no issue while flushing (R8)
   assign req_eff = req & {ENTRIES{~flush}};

   iq_pick #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .AGE_W(AGE_W), .IDX_W(IDX_W)) pick_i (
      .req  (req_eff),
      .ages (ages_pk),
      .gnt  (gnt),
      .pv   (pv),
      .pidx (pidx)
   );

   assign open = ~busy | gnt;

   iq_alloc #(.ENTRIES(ENTRIES)) alloc_i (
      .open   (open),
      .any    (any_open),
      .onehot (pick_slot)
   );

   assign disp_ready = any_open & ~flush;
   assign wr_en      = pick_slot & {ENTRIES{disp_valid & disp_ready}};
   assign iss_valid  = pv;

   always_comb begin
      iss_dst = '0;
      for (int k = 0; k < WIDTH; k++) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (pidx[k*IDX_W +: IDX_W] == IDX_W'(i))
               iss_dst[k*TAG_W +: TAG_W] = slot_dst[i];
         end
      end
   end

   // issued tags become next cycle's wakeup buses (R2, R3)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_vld <= '0;
         bus_tag <= '0;
      end else begin
         bus_vld <= flush ? '0 : pv;
         bus_tag <= iss_dst;
      end
   end

   // R4
   iq_grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   // R4
   iq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gnt) <= WIDTH);
   // R8
   iq_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> iss_valid == '0);
   // R6
   iq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy) && (gnt == '0) |-> !disp_ready);

   for (genvar k = 1; k < WIDTH; k++) begin : g_pack
      // R4
      iq_port_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[k] |-> iss_valid[k-1]);
   end
endmodule

// File: tb/wakeup_select_iq_tb_top.sv
`timescale 1ns/1ps
module wakeup_select_iq_tb_top;
   localparam int E = 8, W = 2, TW = 6, AW = 4;
   localparam int AMAX = (1 << AW) - 1;

   logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, disp_valid = 1'b0;
   logic [TW-1:0] sl = '0, sr = '0, dd = '0;
   logic rl = 1'b0, rr = 1'b0;
   logic disp_ready;
   logic [W-1:0] iv;
   logic [W*TW-1:0] idst;

   always #2.5 clk = ~clk;

   wakeup_select_iq #(.ENTRIES(E), .WIDTH(W), .TAG_W(TW), .AGE_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
      .disp_ready(disp_ready), .disp_src_l(sl), .disp_src_l_rdy(rl),
      .disp_src_r(sr), .disp_src_r_rdy(rr), .disp_dst(dd),
      .iss_valid(iv), .iss_dst(idst));

   int checks = 0, errors = 0;
   bit done = 0;

   bit mv[E]; int ml[E]; int mr[E]; int md[E]; int mage[E]; bit mrl[E]; bit mrr[E];
   bit bv[W]; int bt[W];
   bit o_iv[W]; int o_d[W]; bit o_rdy;

   function automatic bit hit(int t);
      for (int k = 0; k < W; k++) if (bv[k] && bt[k] == t) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check(bit ok, string rq, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic step(bit dv, int a_sl, bit a_rl, int a_sr, bit a_rr, int a_d, bit fl);
      bit rq[E]; bit tk[E]; bit ev[W]; int ed[W]; int alloc; bit erdy;
      int best; int bi;
      @(negedge clk);
      disp_valid = dv; sl = TW'(a_sl); rl = a_rl; sr = TW'(a_sr); rr = a_rr;
      dd = TW'(a_d); flush = fl;
      #1;
      for (int i = 0; i < E; i++) begin
         rq[i] = !fl && mv[i] && (mrl[i] || hit(ml[i])) && (mrr[i] || hit(mr[i]));
         tk[i] = 1'b0;
      end
      for (int k = 0; k < W; k++) begin
         ev[k] = 1'b0; ed[k] = 0; best = -1; bi = -1;
         for (int i = 0; i < E; i++)
            if (rq[i] && !tk[i] && mage[i] > best) begin best = mage[i]; bi = i; end
         if (bi >= 0) begin tk[bi] = 1'b1; ev[k] = 1'b1; ed[k] = md[bi]; end
      end
      alloc = -1;
      for (int i = 0; i < E; i++) if (alloc < 0 && (!mv[i] || tk[i])) alloc = i;
      erdy = !fl && alloc >= 0;
      o_rdy = disp_ready;
      check(disp_ready === erdy, "R6", "disp_ready", int'(disp_ready), int'(erdy));
      for (int k = 0; k < W; k++) begin
         o_iv[k] = iv[k];
         o_d[k]  = int'(idst[k*TW +: TW]);
         check(iv[k] === ev[k], "R4", "iss_valid", int'(iv[k]), int'(ev[k]));
         if (ev[k]) check(o_d[k] == ed[k], "R5", "iss_dst", o_d[k], ed[k]);
      end
      @(posedge clk);
      if (fl) begin
         for (int i = 0; i < E; i++) mv[i] = 1'b0;
         for (int k = 0; k < W; k++) bv[k] = 1'b0;
      end else begin
         for (int i = 0; i < E; i++) begin
            if (dv && erdy && i == alloc) begin
               mv[i] = 1'b1; ml[i] = a_sl; mr[i] = a_sr; md[i] = a_d; mage[i] = 0;
               mrl[i] = a_rl || hit(a_sl); mrr[i] = a_rr || hit(a_sr);
            end else if (tk[i]) begin
               mv[i] = 1'b0;
            end else if (mv[i]) begin
               mrl[i] = mrl[i] || hit(ml[i]);
               mrr[i] = mrr[i] || hit(mr[i]);
               if (mage[i] < AMAX) mage[i]++;
            end
         end
         for (int k = 0; k < W; k++) begin bv[k] = ev[k]; bt[k] = ed[k]; end
      end
   endtask

   task automatic idle();
      step(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
   endtask

   task automatic expect_iss(string rq, bit v0, int d0, bit v1, int d1);
      check(o_iv[0] == v0, rq, "port0 valid", int'(o_iv[0]), int'(v0));
      if (v0) check(o_d[0] == d0, rq, "port0 dst", o_d[0], d0);
      check(o_iv[1] == v1, rq, "port1 valid", int'(o_iv[1]), int'(v1));
      if (v1) check(o_d[1] == d1, rq, "port1 dst", o_d[1], d1);
   endtask

   task automatic age_case(bit saturate);
      step(1'b1, 60, 1'b0, 0, 1'b1, 61, 1'b0);   // slot0 waits on 60
      step(1'b1, 40, 1'b0, 0, 1'b1, 52, 1'b0);   // slot1 older, waits on 40
      step(1'b1, 0, 1'b1, 0, 1'b1, 60, 1'b0);    // producer of 60
      idle();                                     // 60 issues
      step(1'b1, 40, 1'b0, 0, 1'b1, 53, 1'b0);   // 61 issues; younger reuses slot0
      if (saturate) repeat (20) idle();
      step(1'b1, 0, 1'b1, 0, 1'b1, 40, 1'b0);    // producer of 40
      idle();                                     // 40 issues
      idle();
      // R5: older first, lower index on saturated tie
      if (saturate) expect_iss("R5", 1'b1, 53, 1'b1, 52);
      else          expect_iss("R5", 1'b1, 52, 1'b1, 53);
   endtask

   initial begin
      #1ms;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < E; i++) begin mv[i] = 0; mage[i] = 0; end
      for (int k = 0; k < W; k++) begin bv[k] = 0; bt[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1
      check(disp_ready === 1'b1, "R1", "disp_ready", int'(disp_ready), 1);
      check(iv === '0, "R1", "iss_valid", int'(iv), 0);

      // R9 / R3: dependence chain, consumers dispatched first
      step(1'b1, 1, 1'b0, 0, 1'b1, 2, 1'b0);
      step(1'b1, 1, 1'b0, 0, 1'b1, 3, 1'b0);
      step(1'b1, 1, 1'b0, 0, 1'b1, 4, 1'b0);
      step(1'b1, 2, 1'b0, 3, 1'b0, 5, 1'b0);
      step(1'b1, 4, 1'b0, 5, 1'b0, 6, 1'b0);
      step(1'b1, 0, 1'b1, 0, 1'b1, 1, 1'b0);
      idle(); expect_iss("R9", 1'b1, 1, 1'b0, 0);
      idle(); expect_iss("R3", 1'b1, 2, 1'b1, 3);
      idle(); expect_iss("R9", 1'b1, 4, 1'b1, 5);
      idle(); expect_iss("R3", 1'b1, 6, 1'b0, 0);
      idle(); expect_iss("R9", 1'b0, 0, 1'b0, 0);

      // R7: dispatch while the producer tag is on the bus
      step(1'b1, 0, 1'b1, 0, 1'b1, 9, 1'b0);
      idle(); expect_iss("R7", 1'b1, 9, 1'b0, 0);
      step(1'b1, 9, 1'b0, 0, 1'b1, 10, 1'b0);
      idle(); expect_iss("R7", 1'b1, 10, 1'b0, 0);

      // R2: one source never woken keeps the slot from issuing
      step(1'b1, 0, 1'b1, 20, 1'b0, 11, 1'b0);
      repeat (4) begin idle(); expect_iss("R2", 1'b0, 0, 1'b0, 0); end

      // R6: fill the queue, extra dispatch dropped
      for (int j = 0; j < E - 1; j++) step(1'b1, 20, 1'b0, 0, 1'b1, 12 + j, 1'b0);
      step(1'b1, 0, 1'b1, 0, 1'b1, 25, 1'b0);
      check(o_rdy == 1'b0, "R6", "full disp_ready", int'(o_rdy), 0);
      idle(); expect_iss("R6", 1'b0, 0, 1'b0, 0);

      // R8: flush overlapping a dispatch
      step(1'b1, 0, 1'b1, 0, 1'b1, 30, 1'b1);
      check(o_rdy == 1'b0, "R8", "flush disp_ready", int'(o_rdy), 0);
      idle(); expect_iss("R8", 1'b0, 0, 1'b0, 0);
      check(o_rdy == 1'b1, "R8", "empty disp_ready", int'(o_rdy), 1);
      step(1'b1, 0, 1'b1, 0, 1'b1, 31, 1'b0);
      idle(); expect_iss("R8", 1'b1, 31, 1'b0, 0);
      idle(); expect_iss("R8", 1'b0, 0, 1'b0, 0);

      // R5: age beats index, then saturated tie goes to lower index
      age_case(1'b0);
      age_case(1'b1);
      step(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b1);

      // randomized sweep against the arithmetic model
      for (int n = 0; n < 4000; n++) begin
         step(($urandom_range(0, 9) < 6), $urandom_range(0, 15), ($urandom_range(0, 9) < 3),
              $urandom_range(0, 15), ($urandom_range(0, 9) < 3), $urandom_range(0, 15),
              ($urandom_range(0, 49) == 0));
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule